// File: doc/BRIEF.md
# PHY Receive Error Statistics Counters

This block keeps two small management statistics counters for the receive side of a 100 Mb/s Ethernet physical layer. The first one counts false carrier indications. The second one counts carrier events that were spoiled by an invalid data symbol. A carrier event counts at most once in the second counter, and it does not count at all if a collision was seen while it was open. Both counters stop at their full-scale value instead of wrapping. Management software reads them through a simple single-cycle register bus, and each read clears the counter it touches.

The receive PCS supplies four per-clock inputs: a carrier-active level, an invalid-symbol strobe, a false-carrier strobe and a collision level. Each counter appears in the low bits of a 16-bit register. The upper bits of that register always read as zero. Software can also load a counter with any value through a register write.

Top module: `phy_err_stats`

## Requirements
- R1: After reset both counters are zero, so reading offset 0 and offset 1 returns 0000h.
- R2: The false-carrier counter (offset 0) adds one for every clock cycle in which `false_carr` is high.
- R3: Both counters saturate at FFh and hold that value while further events arrive.
- R4: A read (`bus_sel`=1, `bus_wr`=0) presents the counter at `bus_addr` on `bus_rdata` one cycle later. Offset 0 is the false-carrier counter and offset 1 is the receive-error counter. The count sits in bits 7:0 and bits 15:8 read as 0. The counter that was read is then zero.
- R5: The receive-error counter (offset 1) advances only in a cycle where `bad_sym` and `carrier_on` are both high. A `bad_sym` pulse while `carrier_on` is low is ignored.
- R6: The receive-error counter advances at most once per carrier event, where an event is a run of cycles with `carrier_on` high. Extra invalid symbols in the same event are ignored.
- R7: A collision in any cycle of a carrier event, up to and including the cycle of the invalid symbol, blocks the receive-error count for the rest of that event. The block lifts once `carrier_on` goes low.
- R8: If a read clears a counter in the same cycle that counter receives an event, the read returns the old value and the counter then holds 1.
- R9: A write loads bits 7:0 of `bus_wdata` into the addressed counter and ignores bits 15:8. If a write and an event hit the same counter in the same cycle, the written value wins.
- R10: A read of any offset other than 0 and 1 returns 0000h. `bus_rdata` is 0000h in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| carrier_on | input | 1 | Receive carrier active (level) |
| bad_sym | input | 1 | Invalid data symbol seen this cycle (strobe) |
| false_carr | input | 1 | False carrier detected this cycle (strobe) |
| collision | input | 1 | Collision present (level) |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read |

## Verification
Every event strobe is counted at the same rising edge that samples it. Read data appears in the register that the next rising edge loads, so a read issued in cycle n is seen in cycle n+1. The bench drives all inputs on the falling edge and holds each access or strobe for exactly one rising edge. It samples `bus_rdata` on the following falling edge, where both the read data and the clear that came with it have settled. In the coincident read-and-event and write-and-event cases, stimulus and access share one cycle, and a second read confirms the value the counter kept.

// File: rtl/phy_err_stats_pkg.sv
package phy_err_stats_pkg;

   localparam int IDX_FALSE_CARR = 0;
   localparam int IDX_RX_ERR     = 1;
   localparam int NUM_STATS      = 2;

   typedef enum logic [1:0] {
      CNT_HOLD,
      CNT_LOAD,
      CNT_CLEAR,
      CNT_STEP
   } cnt_op_e;

   function automatic cnt_op_e pick_op(input logic wr_en,
                                       input logic rd_clr,
                                       input logic inc);
      if (wr_en)       return CNT_LOAD;
      else if (rd_clr) return CNT_CLEAR;
      else if (inc)    return CNT_STEP;
      else             return CNT_HOLD;
   endfunction

endpackage

// File: rtl/pes_counter.sv
module pes_counter
   import phy_err_stats_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             rd_clr,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_val,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("pes_counter: CNT_W must be at least 1");
      end
   endgenerate

   cnt_op_e          op;
   logic [CNT_W-1:0] step_val;

   assign op = pick_op(wr_en, rd_clr, inc);

   generate
      if (SATURATE) begin : g_sat
         assign step_val = (cnt == CNT_MAX) ? CNT_MAX : cnt + CNT_ONE;
      end else begin : g_wrap
         assign step_val = cnt + CNT_ONE;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else begin
         unique case (op)
            CNT_LOAD:  cnt <= wr_val;
            CNT_CLEAR: cnt <= inc ? CNT_ONE : '0;
            CNT_STEP:  cnt <= step_val;
            default:   cnt <= cnt;
         endcase
      end
   end

   generate
      if (SATURATE) begin : g_sat_chk
         a_r3_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt == CNT_MAX && !wr_en && !rd_clr) |=> (cnt == CNT_MAX));
      end
   endgenerate

   a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !wr_en && !rd_clr && cnt != CNT_MAX) |=> (cnt == $past(cnt) + CNT_ONE));

   a_r8_clear_keeps_event: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !wr_en) |=> (cnt == ($past(inc) ? CNT_ONE : '0)));

   a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (cnt == $past(wr_val)));

endmodule

// File: rtl/pes_rxerr_qual.sv
module pes_rxerr_qual #(
   parameter bit COL_LATCH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic carrier_on,
   input  logic bad_sym,
   input  logic collision,
   output logic qual
);

   logic counted_q;
   logic col_seen;

   generate
      if (COL_LATCH) begin : g_col_latch
         logic col_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          col_q <= 1'b0;
            else if (!carrier_on) col_q <= 1'b0;
            else if (collision)  col_q <= 1'b1;
         end
         assign col_seen = col_q | collision;
      end else begin : g_col_live
         assign col_seen = collision;
      end
   endgenerate

   assign qual = carrier_on & bad_sym & ~counted_q & ~col_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           counted_q <= 1'b0;
      else if (!carrier_on) counted_q <= 1'b0;
      else if (qual)        counted_q <= 1'b1;
   end

   a_r5_needs_carrier: assert property (@(posedge clk) disable iff (!rst_n)
      qual |-> (carrier_on && bad_sym));

   a_r6_once_per_event: assert property (@(posedge clk) disable iff (!rst_n)
      qual |=> !qual);

   a_r7_collision_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      collision |-> !qual);

endmodule

// File: rtl/pes_regif.sv
module pes_regif #(
   parameter int ADDR_W   = 4,
   parameter int REG_W    = 16,
   parameter int CNT_W    = 8,
   parameter int NUM_CNT  = 2,
   parameter int BASE_OFS = 0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_sel,
   input  logic                     bus_wr,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [REG_W-1:0]         bus_wdata,
   input  logic [NUM_CNT*CNT_W-1:0] cnt_flat,
   output logic [NUM_CNT-1:0]       rd_clr,
   output logic [NUM_CNT-1:0]       wr_en,
   output logic [CNT_W-1:0]         wr_val,
   output logic [REG_W-1:0]         bus_rdata
);

   localparam int PAD_W = REG_W - CNT_W;

   generate
      if (CNT_W > REG_W) begin : g_bad_w
         $error("pes_regif: CNT_W exceeds REG_W");
      end
      if (BASE_OFS + NUM_CNT > (1 << ADDR_W)) begin : g_bad_map
         $error("pes_regif: counters do not fit the address window");
      end
   endgenerate

   logic [NUM_CNT-1:0] hit;
   logic               rd_req;
   logic [REG_W-1:0]   rd_mux;

   assign rd_req = bus_sel & ~bus_wr;
   assign wr_val = bus_wdata[CNT_W-1:0];

   generate
      for (genvar i = 0; i < NUM_CNT; i++) begin : g_dec
         assign hit[i]    = bus_sel && (bus_addr == ADDR_W'(BASE_OFS + i));
         assign rd_clr[i] = hit[i] & ~bus_wr;
         assign wr_en[i]  = hit[i] & bus_wr;
      end
      if (PAD_W > 0) begin : g_pad
         logic unused_wdata_hi;
         assign unused_wdata_hi = ^bus_wdata[REG_W-1:CNT_W];
      end
   endgenerate

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NUM_CNT; i++) begin
         if (hit[i]) rd_mux = REG_W'(cnt_flat[i*CNT_W +: CNT_W]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (rd_req) bus_rdata <= rd_mux;
      else             bus_rdata <= '0;
   end

   a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> (bus_rdata == '0));

   a_r4_read_value: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> (bus_rdata == $past(rd_mux)));

   generate
      if (PAD_W > 0) begin : g_pad_chk
         always_comb begin
            if (rst_n) begin
               a_r4_upper_zero: assert (bus_rdata[REG_W-1:CNT_W] == '0);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/phy_err_stats.sv
module phy_err_stats
   import phy_err_stats_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int REG_W     = 16,
   parameter int CNT_W     = 8,
   parameter int BASE_OFS  = 0,
   parameter bit SATURATE  = 1'b1,
   parameter bit COL_LATCH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              carrier_on,
   input  logic              bad_sym,
   input  logic              false_carr,
   input  logic              collision,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata
);

   localparam int NC = NUM_STATS;

   logic [NC-1:0]       inc;
   logic [NC-1:0]       rd_clr;
   logic [NC-1:0]       wr_en;
   logic [CNT_W-1:0]    wr_val;
   logic [NC*CNT_W-1:0] cnt_flat;
   logic                rx_qual;

   pes_rxerr_qual #(.COL_LATCH(COL_LATCH)) u_qual (
      .clk        (clk),
      .rst_n      (rst_n),
      .carrier_on (carrier_on),
      .bad_sym    (bad_sym),
      .collision  (collision),
      .qual       (rx_qual)
   );

   assign inc[IDX_FALSE_CARR] = false_carr;
   assign inc[IDX_RX_ERR]     = rx_qual;

   generate
      for (genvar i = 0; i < NC; i++) begin : g_cnt
         pes_counter #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc    (inc[i]),
            .rd_clr (rd_clr[i]),
            .wr_en  (wr_en[i]),
            .wr_val (wr_val),
            .cnt    (cnt_flat[i*CNT_W +: CNT_W])
         );
      end
   endgenerate

   pes_regif #(
      .ADDR_W   (ADDR_W),
      .REG_W    (REG_W),
      .CNT_W    (CNT_W),
      .NUM_CNT  (NC),
      .BASE_OFS (BASE_OFS)
   ) u_regif (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .cnt_flat  (cnt_flat),
      .rd_clr    (rd_clr),
      .wr_en     (wr_en),
      .wr_val    (wr_val),
      .bus_rdata (bus_rdata)
   );

   a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (bus_rdata == '0));

endmodule

// File: tb/sim_phy_err_stats.sv
module sim_phy_err_stats;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        carrier_on = 1'b0, bad_sym = 1'b0, false_carr = 1'b0, collision = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   phy_err_stats u0 (
      .clk(clk), .rst_n(rst_n), .carrier_on(carrier_on), .bad_sym(bad_sym),
      .false_carr(false_carr), .collision(collision), .bus_sel(bus_sel),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata)
   );

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %04h expected %04h", req, got, exp);
      end
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk); bus_sel = 1'b0; d = bus_rdata;
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] v);
      @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
      @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic fc_pulse(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); false_carr = 1'b1;
      end
      @(negedge clk); false_carr = 1'b0;
   endtask

   // mode: 0 clean, 1 collision before first bad symbol, 2 collision with it, 3 after it
   task automatic rx_event(input int nbad, input int mode);
      @(negedge clk); carrier_on = 1'b1;
      if (mode == 1) begin
         @(negedge clk); collision = 1'b1;
         @(negedge clk); collision = 1'b0;
      end
      for (int i = 0; i < nbad; i++) begin
         @(negedge clk); bad_sym = 1'b1; collision = (mode == 2);
         @(negedge clk); bad_sym = 1'b0; collision = 1'b0;
      end
      if (mode == 3) begin
         @(negedge clk); collision = 1'b1;
         @(negedge clk); collision = 1'b0;
      end
      @(negedge clk); carrier_on = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(4'd0, d); check("R1 false-carrier reset", d, 16'h0000);
      rd(4'd1, d); check("R1 rx-error reset", d, 16'h0000);

      // R10 unmapped offsets and idle cycles
      for (int a = 2; a < 16; a++) begin
         fc_pulse(1);
         rd(4'(a), d); check("R10 unmapped offset", d, 16'h0000);
      end
      rd(4'd0, d); check("R2 count under unmapped reads", d, 16'd14);
      @(negedge clk); check("R10 idle rdata", bus_rdata, 16'h0000);

      // R2 / R4 sweep of burst lengths
      for (int n = 1; n <= 40; n += 3) begin
         fc_pulse(n);
         rd(4'd0, d); check("R2 false-carrier burst", d, 16'(n));
         rd(4'd0, d); check("R4 cleared by read", d, 16'h0000);
      end

      // R3 saturation
      fc_pulse(300);
      rd(4'd0, d); check("R3 false-carrier saturate", d, 16'h00FF);
      for (int k = 0; k < 300; k++) rx_event(1, 0);
      rd(4'd1, d); check("R3 rx-error saturate", d, 16'h00FF);
      rd(4'd1, d); check("R4 rx-error cleared", d, 16'h0000);

      // R5 bad symbol without carrier
      for (int k = 0; k < 5; k++) begin
         @(negedge clk); bad_sym = 1'b1;
         @(negedge clk); bad_sym = 1'b0;
      end
      rd(4'd1, d); check("R5 no carrier ignored", d, 16'h0000);

      // R6 once per event regardless of symbol count
      for (int k = 1; k <= 6; k++) begin
         rx_event(k, 0);
         rd(4'd1, d); check("R6 once per event", d, 16'h0001);
      end
      for (int k = 1; k <= 4; k++) rx_event(k, 0);
      rd(4'd1, d); check("R6 four events", d, 16'h0004);

      // R7 collision blocking
      rx_event(3, 1);
      rd(4'd1, d); check("R7 earlier collision blocks", d, 16'h0000);
      rx_event(1, 2);
      rd(4'd1, d); check("R7 same-cycle collision blocks", d, 16'h0000);
      rx_event(2, 3);
      rd(4'd1, d); check("R7 late collision keeps count", d, 16'h0001);
      rx_event(1, 1);
      rx_event(1, 0);
      rd(4'd1, d); check("R7 block lifts after carrier drop", d, 16'h0001);

      // R8 read-clear with simultaneous event
      fc_pulse(5);
      @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'd0; false_carr = 1'b1;
      @(negedge clk); bus_sel = 1'b0; false_carr = 1'b0; d = bus_rdata;
      check("R8 read returns old value", d, 16'd5);
      rd(4'd0, d); check("R8 event kept after clear", d, 16'h0001);

      // R9 writes
      wr(4'd0, 16'hAB5C);
      rd(4'd0, d); check("R9 write low byte only", d, 16'h005C);
      @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd0;
      bus_wdata = 16'h1234; false_carr = 1'b1;
      @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0; false_carr = 1'b0;
      rd(4'd0, d); check("R9 write beats increment", d, 16'h0034);
      wr(4'd1, 16'h00FD);
      rx_event(1, 0); rx_event(1, 0); rx_event(1, 0);
      rd(4'd1, d); check("R9 R3 preload then saturate", d, 16'h00FF);
      wr(4'd5, 16'h0077);
      rd(4'd0, d); check("R10 unmapped write no effect", d, 16'h0000);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule